// File: doc/BRIEF.md
# Direct-Indexed Page Translation Cache

This block keeps up to 32 recent linear-to-physical page translations so that a page walker is only needed on a miss. Each entry sits at a fixed slot chosen by five linear address bits. There is no associative search. A slot holds a tag, a physical frame number, a valid flag and a global flag.

A lookup address is presented on every cycle. On the next clock edge the block registers a hit flag and the physical address. When a walk finishes, the walker writes the page number and the table entry it found. The slot for that page is overwritten.

Two kinds of flush are supported:
- a normal flush, which keeps global translations;
- a full flush, which clears every slot.

A single page can also be dropped by its page number. A build parameter selects an older configuration in which the global flag is never kept. In that configuration every flush empties the cache.

Top module: `xlat_cache`

## Requirements
- R1: While reset is held and after it is released, every slot is invalid, so the first lookup after reset reports a miss with physical address 0.
- R2: The slot index is linear bits 16:12, with bits 14:12 as the set and bits 16:15 as the way. The tag is linear bits 31:17. A lookup hits when the indexed slot is valid and its tag equals the tag of the lookup address. The result is registered and appears after the clock edge that samples the lookup address.
- R3: On a hit the physical address is the stored 20-bit frame in bits 31:12, joined with lookup bits 11:0. On a miss it is 0.
- R4: An update writes the slot indexed by the update page number and marks it valid. It stores the page tag and the frame, which is table entry bits 31:12.
- R5: The update sets the global flag when table entry bit 8 is 1. It clears any earlier global flag when bit 8 is 0.
- R6: A flush with the full-flush select low invalidates every slot whose global flag is clear. Global slots keep their translations.
- R7: A flush with the full-flush select high invalidates every slot.
- R8: An invalidate clears the indexed slot only if that slot is valid and its tag matches. A mismatching invalidate leaves the slot, and every other slot, unchanged.
- R9: With the global support parameter at 0, bit 8 of the table entry is ignored and every flush invalidates every slot.
- R10: Update, invalidate and flush requests in the same cycle as a lookup take effect before that lookup. The update is applied first, and then the invalidate and the flush.
- R11: Two pages that share index bits 16:12 but differ in tag evict each other. A lookup of the page that was overwritten misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupAddr | input | 32 | Linear address looked up every cycle |
| lookupHit | output | 1 | Registered hit flag |
| lookupPaddr | output | 32 | Registered physical address, 0 on miss |
| updValid | input | 1 | Write a translation this cycle |
| updPage | input | 20 | Linear page number (linear bits 31:12) to write |
| updEntry | input | 32 | Table entry: frame in bits 31:12, global in bit 8 |
| invReq | input | 1 | Invalidate one page this cycle |
| invPage | input | 20 | Linear page number to invalidate |
| flushReq | input | 1 | Flush request |
| flushAll | input | 1 | With flushReq, clear global slots too |

## Verification
The hardest situations to reach from the ports combine global and non-global slots with several maintenance requests in one cycle. Examples are a normal flush, or an invalidate, in the same cycle as a lookup of that very slot. Another is an update that turns a global slot back into a non-global one just before a flush.

The random stimulus draws addresses from four tags, so slots collide and lookups hit often. It sets the global bit in half of the updates. It overlaps update, invalidate and flush requests freely. Directed steps then place each of these orderings on a single slot.

A second instance, built with global support off, receives the same stimulus.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  localparam int LIN_W      = 32;
  localparam int OFS_W      = 12;
  localparam int SET_W      = 3;
  localparam int WAY_W      = 2;
  localparam int IDX_W      = SET_W + WAY_W;
  localparam int TAG_W      = LIN_W - OFS_W - IDX_W;
  localparam int PAGE_W     = LIN_W - OFS_W;
  localparam int ENTRIES    = 1 << IDX_W;
  localparam int GLOBAL_BIT = 8;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [TAG_W-1:0]  wrTag;
    logic [PAGE_W-1:0] wrFrame;
    logic              wrGlobal;
    logic              invEn;
    logic [IDX_W-1:0]  invIdx;
    logic [TAG_W-1:0]  invTag;
    logic              flushLocal;
    logic              flushEvery;
  } maintStrobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_cache_pkg::*;
#(
  parameter bit GLOBAL_EN = 1'b1
) (
  input  logic              updValid,
  input  logic [PAGE_W-1:0] updPage,
  input  logic [LIN_W-1:0]  updEntry,
  input  logic              invReq,
  input  logic [PAGE_W-1:0] invPage,
  input  logic              flushReq,
  input  logic              flushAll,
  output maintStrobe_t      strb
);
  logic entryGlobal;
  logic flushEveryN;

  generate
    if (GLOBAL_EN) begin : gGlobal
      assign entryGlobal = updEntry[GLOBAL_BIT];
      assign flushEveryN = flushReq & flushAll;
    end else begin : gLegacy
      logic legacyUnused;
      assign legacyUnused = updEntry[GLOBAL_BIT] ^ flushAll;
      assign entryGlobal = 1'b0;
      assign flushEveryN = flushReq;
    end
  endgenerate

  logic entryUnused;
  assign entryUnused = ^{updEntry[OFS_W-1:GLOBAL_BIT+1], updEntry[GLOBAL_BIT-1:0]};

  always_comb begin
    strb            = '0;
    strb.wrEn       = updValid;
    strb.wrIdx      = updPage[IDX_W-1:0];
    strb.wrTag      = updPage[PAGE_W-1 -: TAG_W];
    strb.wrFrame    = updEntry[LIN_W-1:OFS_W];
    strb.wrGlobal   = entryGlobal;
    strb.invEn      = invReq;
    strb.invIdx     = invPage[IDX_W-1:0];
    strb.invTag     = invPage[PAGE_W-1 -: TAG_W];
    strb.flushEvery = flushEveryN;
    strb.flushLocal = flushReq & ~flushEveryN;
  end
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_cache_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  maintStrobe_t     strb,
  input  logic [LIN_W-1:0] lookupAddr,
  output logic             lookupHit,
  output logic [LIN_W-1:0] lookupPaddr
);
  logic [ENTRIES-1:0] validQ, validD, globalQ, globalD;
  logic [TAG_W-1:0]   tagQ   [ENTRIES];
  logic [TAG_W-1:0]   tagD   [ENTRIES];
  logic [PAGE_W-1:0]  frameQ [ENTRIES];
  logic [PAGE_W-1:0]  frameD [ENTRIES];

  // next state: update first, then invalidate and flush
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      validD[i]  = validQ[i];
      globalD[i] = globalQ[i];
      tagD[i]    = tagQ[i];
      frameD[i]  = frameQ[i];
      if (strb.wrEn && strb.wrIdx == IDX_W'(i)) begin
        validD[i]  = 1'b1;
        globalD[i] = strb.wrGlobal;
        tagD[i]    = strb.wrTag;
        frameD[i]  = strb.wrFrame;
      end
      if (strb.invEn && strb.invIdx == IDX_W'(i) && validD[i] && tagD[i] == strb.invTag)
        validD[i] = 1'b0;
      if (strb.flushEvery || (strb.flushLocal && !globalD[i]))
        validD[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= '0;
      globalQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]   <= '0;
        frameQ[i] <= '0;
      end
    end else begin
      validQ  <= validD;
      globalQ <= globalD;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]   <= tagD[i];
        frameQ[i] <= frameD[i];
      end
    end
  end

  // lookup against the post-maintenance state
  logic [IDX_W-1:0] lkIdx;
  logic [TAG_W-1:0] lkTag;
  logic             lkHit;
  assign lkIdx = lookupAddr[OFS_W +: IDX_W];
  assign lkTag = lookupAddr[LIN_W-1 -: TAG_W];
  assign lkHit = validD[lkIdx] && (tagD[lkIdx] == lkTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookupHit   <= 1'b0;
      lookupPaddr <= '0;
    end else begin
      lookupHit   <= lkHit;
      lookupPaddr <= lkHit ? {frameD[lkIdx], lookupAddr[OFS_W-1:0]} : '0;
    end
  end

  a_r1_reset_miss: assert property (@(posedge clk) !rstN |=> !lookupHit);
  a_r7_full_flush_miss: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushEvery |=> !lookupHit);
  a_r8_inval_miss: assert property (@(posedge clk) disable iff (!rstN)
    strb.invEn && strb.invIdx == lkIdx && strb.invTag == lkTag |=> !lookupHit);
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> lookupPaddr[OFS_W-1:0] == $past(lookupAddr[OFS_W-1:0]));
  a_r10_update_visible: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn && strb.wrIdx == lkIdx && strb.wrTag == lkTag && !strb.invEn
    && !strb.flushLocal && !strb.flushEvery
    |=> lookupHit && lookupPaddr[LIN_W-1:OFS_W] == $past(strb.wrFrame));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter bit GLOBAL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LIN_W-1:0]  lookupAddr,
  output logic              lookupHit,
  output logic [LIN_W-1:0]  lookupPaddr,
  input  logic              updValid,
  input  logic [PAGE_W-1:0] updPage,
  input  logic [LIN_W-1:0]  updEntry,
  input  logic              invReq,
  input  logic [PAGE_W-1:0] invPage,
  input  logic              flushReq,
  input  logic              flushAll
);
  maintStrobe_t strb;

  xlat_ctrl #(.GLOBAL_EN(GLOBAL_EN)) uCtrl (
    .updValid(updValid), .updPage(updPage), .updEntry(updEntry),
    .invReq(invReq), .invPage(invPage),
    .flushReq(flushReq), .flushAll(flushAll), .strb(strb)
  );

  xlat_store uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .lookupAddr(lookupAddr),
    .lookupHit(lookupHit), .lookupPaddr(lookupPaddr)
  );
endmodule

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic        updValid = 1'b0;
  logic [19:0] updPage = '0;
  logic [31:0] updEntry = '0;
  logic        invReq = 1'b0;
  logic [19:0] invPage = '0;
  logic        flushReq = 1'b0;
  logic        flushAll = 1'b0;
  logic        hitM, hitL;
  logic [31:0] paM, paL;

  always #5 clk = ~clk;

  xlat_cache #(.GLOBAL_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .lookupHit(hitM), .lookupPaddr(paM),
    .updValid(updValid), .updPage(updPage), .updEntry(updEntry),
    .invReq(invReq), .invPage(invPage), .flushReq(flushReq), .flushAll(flushAll));

  xlat_cache #(.GLOBAL_EN(1'b0)) dutLegacy (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .lookupHit(hitL), .lookupPaddr(paL),
    .updValid(updValid), .updPage(updPage), .updEntry(updEntry),
    .invReq(invReq), .invPage(invPage), .flushReq(flushReq), .flushAll(flushAll));

  // reference model: index [0] global-capable, [1] legacy
  logic        mv [2][32];
  logic        mg [2][32];
  logic [14:0] mt [2][32];
  logic [19:0] mf [2][32];
  int vectors = 0, misses = 0;
  bit done = 1'b0;

  function automatic logic [31:0] expPa(input int k, input logic [31:0] la);
    int idx = int'(la[16:12]);
    if (mv[k][idx] && mt[k][idx] == la[31:17]) return {mf[k][idx], la[11:0]};
    return 32'd0;
  endfunction

  function automatic logic expHit(input int k, input logic [31:0] la);
    int idx = int'(la[16:12]);
    return mv[k][idx] && mt[k][idx] == la[31:17];
  endfunction

  task automatic modelClear();
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 32; i++) begin
        mv[k][i] = 0; mg[k][i] = 0; mt[k][i] = '0; mf[k][i] = '0;
      end
  endtask

  task automatic modelStep();
    for (int k = 0; k < 2; k++) begin
      if (updValid) begin
        int i = int'(updPage[4:0]);
        mv[k][i] = 1; mt[k][i] = updPage[19:5]; mf[k][i] = updEntry[31:12];
        mg[k][i] = (k == 0) ? updEntry[8] : 1'b0;
      end
      if (invReq) begin
        int i = int'(invPage[4:0]);
        if (mv[k][i] && mt[k][i] == invPage[19:5]) mv[k][i] = 0;
      end
      if (flushReq)
        for (int i = 0; i < 32; i++)
          if (flushAll || !mg[k][i]) mv[k][i] = 0;
    end
  endtask

  task automatic compare(input string req, input logic eh0, input logic [31:0] ep0,
                         input logic eh1, input logic [31:0] ep1);
    vectors++;
    if (hitM !== eh0 || paM !== ep0) begin
      misses++;
      $display("FAIL %s main: hit=%0b pa=%h expected hit=%0b pa=%h", req, hitM, paM, eh0, ep0);
    end
    vectors++;
    if (hitL !== eh1 || paL !== ep1) begin
      misses++;
      $display("FAIL %s legacy: hit=%0b pa=%h expected hit=%0b pa=%h", req, hitL, paL, eh1, ep1);
    end
  endtask

  // drive at negedge, model the edge, compare at the following negedge
  task automatic step(input logic [31:0] la, input logic uv, input logic [19:0] up,
                      input logic [31:0] ue, input logic iv, input logic [19:0] ip,
                      input logic fr, input logic fa, input string req);
    logic eh0, eh1;
    logic [31:0] ep0, ep1;
    lookupAddr = la; updValid = uv; updPage = up; updEntry = ue;
    invReq = iv; invPage = ip; flushReq = fr; flushAll = fa;
    modelStep();
    eh0 = expHit(0, la); ep0 = expPa(0, la);
    eh1 = expHit(1, la); ep1 = expPa(1, la);
    @(posedge clk);
    @(negedge clk);
    compare(req, eh0, ep0, eh1, ep1);
  endtask

  task automatic look(input logic [31:0] la, input string req);
    step(la, 0, '0, '0, 0, '0, 0, 0, req);
  endtask

  initial begin
    logic [31:0] pgA, pgA2, pgB;
    logic [14:0] tagPool [4];
    tagPool[0] = 15'h0000; tagPool[1] = 15'h0001; tagPool[2] = 15'h7fff; tagPool[3] = 15'h1234;
    modelClear();
    repeat (3) @(negedge clk);
    // R1: reset state
    @(negedge clk);
    compare("R1", 0, 0, 0, 0);
    rstN = 1'b1;
    pgA  = {15'h0abc, 5'b10_011, 12'h345};
    pgA2 = {15'h0abd, 5'b10_011, 12'h345};
    pgB  = {15'h0042, 5'b01_110, 12'hfff};
    look(pgA, "R1");
    // R10: update visible to the same-cycle lookup; R4 store
    step(pgA, 1, pgA[31:12], 32'hABCDE000, 0, '0, 0, 0, "R10");
    look(pgA, "R2");
    look({pgA[31:12], 12'h000}, "R3");
    look({pgA[31:12], 12'hfff}, "R3");
    // R11: same index, other tag
    look(pgA2, "R11");
    step(pgA, 1, pgA2[31:12], 32'h11111000, 0, '0, 0, 0, "R11");
    look(pgA2, "R4");
    step(pgA, 1, pgA[31:12], 32'hABCDE000, 0, '0, 0, 0, "R4");
    // R6/R9: global survives normal flush, legacy loses it
    step(pgB, 1, pgB[31:12], 32'h55555100, 0, '0, 0, 0, "R5");
    step(pgB, 0, '0, '0, 0, '0, 1, 0, "R6");
    look(pgA, "R6");
    look(pgB, "R9");
    // R5: rewrite without global bit, then flush clears it
    step(pgB, 1, pgB[31:12], 32'h66666000, 0, '0, 0, 0, "R5");
    step(pgB, 0, '0, '0, 0, '0, 1, 0, "R5");
    // R7: full flush removes global
    step(pgB, 1, pgB[31:12], 32'h77777100, 0, '0, 0, 0, "R7");
    step(pgB, 0, '0, '0, 0, '0, 1, 1, "R7");
    look(pgB, "R7");
    // R8: mismatched invalidate keeps, matched invalidate clears in same cycle
    step(pgA, 1, pgA[31:12], 32'h12345000, 0, '0, 0, 0, "R8");
    step(pgA, 0, '0, '0, 1, pgA2[31:12], 0, 0, "R8");
    step(pgA, 0, '0, '0, 1, pgA[31:12], 0, 0, "R8");
    // R10: update then flush in one cycle
    step(pgA, 1, pgA[31:12], 32'h12345100, 0, '0, 1, 0, "R10");
    step(pgA, 1, pgA[31:12], 32'h12345000, 1, pgA[31:12], 0, 0, "R10");
    // random mix
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] la, ue;
      logic [19:0] up, ip;
      logic uv, iv, fr, fa;
      la = {tagPool[$urandom % 4], 5'($urandom), 12'($urandom)};
      up = {tagPool[$urandom % 4], 5'($urandom)};
      ip = ($urandom % 2 == 0) ? la[31:12] : {tagPool[$urandom % 4], 5'($urandom)};
      ue = {20'($urandom), 3'b000, 1'($urandom), 8'($urandom)};
      uv = ($urandom % 2) == 0;
      iv = ($urandom % 7) == 0;
      fr = ($urandom % 16) == 0;
      fa = ($urandom % 2) == 0;
      step(la, uv, up, ue, iv, ip, fr, fa, "R2 R3 R6 R7 R8");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: hit=%0b pa=%h expected run to end", hitM, paM);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule